// File: doc/BRIEF.md
# Strand Privileged Control Register File

This block holds the privileged control state of one processor strand: a processor-state word carrying an interrupt-enable bit, an interrupt priority level, a hypervisor-state word, a hypervisor trap base address, and eight interrupt-queue pointers. The pointers are a head and a tail for each of four queues: processor mondo, device mondo, resumable error and non-resumable error. The block also has a read-only identification word. Software reaches it through one synchronous port that carries a write strobe, a read strobe, an address and write data.

Writes do more than store a value. Some registers shape the incoming data. The trap base drops its low address bits. The hypervisor-state word always keeps its identification bit set. Any write that could make a pending interrupt deliverable raises a one-cycle `recheck` pulse, which tells the interrupt logic to look again. Such writes are an interrupt enable turning on, a lower priority level, or any queue pointer update.

The block flags a bad access on `err` for one cycle. A bad access is a read or a write to an address that maps to nothing, or a write to the identification word. Actual interrupt delivery, trap entry and queue contents are handled elsewhere.

Top module: `priv_ctl_regs`

## Requirements
- R1: After reset the processor-state, level, trap base and all eight queue registers read 0, the hypervisor-state word reads with only its identification bit (bit 11) set, and `recheck` and `err` are low.
- R2: A write to address 0 stores the processor-state word. `recheck` is raised if and only if the interrupt-enable bit (bit 1) was 0 before the write and is 1 in the written data.
- R3: A write to address 1 stores the low LVL_W bits of the data as the level. `recheck` is raised if and only if the new level is strictly lower than the stored one.
- R4: Addresses 8 to 15 hold the queue pointers. Their order is processor-mondo head and tail, device-mondo head and tail, resumable-error head and tail, then non-resumable-error head and tail. Each write stores its full value and raises `recheck`.
- R5: A write to address 3 stores the trap base with bits 14:0 cleared. A read of it returns those bits as 0.
- R6: A write to address 2 stores the hypervisor-state word with bit 11 forced to 1.
- R7: A read of address 4 returns NWIN in bits 7:0, MAXTL in bits 15:8 and MAXGL in bits 23:16, with all higher bits 0.
- R8: A write to address 4 raises `err`, does not raise `recheck`, and leaves the value read from address 4 unchanged.
- R9: A read of an unmapped address (5 to 7, or 16 and above) returns 0 and raises `err`. A write to an unmapped address raises `err`, does not raise `recheck`, and changes no register.
- R10: `rdata`, `recheck` and `err` are registered and update on the clock edge that samples the access. `recheck` and `err` are high for exactly one cycle per access. `rdata` keeps its value until the next read. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| recheck | output | 1 | One-cycle request to re-evaluate pending interrupts |
| err | output | 1 | One-cycle flag for an illegal or unmapped access |

## Verification
The bench builds the block with DATA_W of 32, so the trap-base mask and the identification word fit in a narrower bus. It sets NWIN=8, MAXTL=6 and MAXGL=2, and because the three field values differ, a swapped or shifted field in the identification word shows up. LVL_W stays at 4, so a written value of 0x1F shows that upper bits are cut off. The level sequence moves up, then to an equal value, then down, which brings the strict less-than boundary within reach.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int A_PSTATE = 0;
  localparam int A_LEVEL  = 1;
  localparam int A_HSTATE = 2;
  localparam int A_TBASE  = 3;
  localparam int A_IDENT  = 4;
  localparam int A_QBASE  = 8;
  localparam int QN       = 8;
  localparam int QIDX_W   = $clog2(QN);

  typedef struct packed {
    logic              pstate;
    logic              level;
    logic              hstate;
    logic              tbase;
    logic              ident;
    logic              queue;
    logic [QIDX_W-1:0] qidx;
    logic              known;
  } sel_t;
endpackage

// File: rtl/prf_decode.sv
module prf_decode #(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output prf_pkg::sel_t     sel
);
  import prf_pkg::*;
  localparam int QSHIFT = QIDX_W;

  always_comb begin
    sel        = '0;
    sel.pstate = (addr == ADDR_W'(A_PSTATE));
    sel.level  = (addr == ADDR_W'(A_LEVEL));
    sel.hstate = (addr == ADDR_W'(A_HSTATE));
    sel.tbase  = (addr == ADDR_W'(A_TBASE));
    sel.ident  = (addr == ADDR_W'(A_IDENT));
    sel.queue  = ((addr >> QSHIFT) == ADDR_W'(A_QBASE >> QSHIFT));
    sel.qidx   = addr[QIDX_W-1:0];
    sel.known  = sel.pstate | sel.level | sel.hstate | sel.tbase |
                 sel.ident | sel.queue;
  end
endmodule

// File: rtl/prf_recheck.sv
module prf_recheck #(
  parameter int LVL_W = 4
) (
  input  prf_pkg::sel_t    sel,
  input  logic             wr_en,
  input  logic             ie_now,
  input  logic             ie_new,
  input  logic [LVL_W-1:0] lvl_now,
  input  logic [LVL_W-1:0] lvl_new,
  output logic             fire
);
  logic ie_rise, lvl_drop;

  always_comb begin
    ie_rise  = sel.pstate & ~ie_now & ie_new;
    lvl_drop = sel.level & (lvl_new < lvl_now);
    fire     = wr_en & (ie_rise | lvl_drop | sel.queue);
  end
endmodule

// File: rtl/prf_readmux.sv
module prf_readmux #(
  parameter int DATA_W = 64,
  parameter int LVL_W  = 4,
  parameter int QN     = 8,
  parameter logic [DATA_W-1:0] IDENT = '0
) (
  input  prf_pkg::sel_t               sel,
  input  logic [DATA_W-1:0]           pstate,
  input  logic [LVL_W-1:0]            level,
  input  logic [DATA_W-1:0]           hstate,
  input  logic [DATA_W-1:0]           tbase,
  input  logic [QN-1:0][DATA_W-1:0]   qptr,
  output logic [DATA_W-1:0]           value
);
  always_comb begin
    value = '0;
    if (sel.pstate)      value = pstate;
    else if (sel.level)  value = {{(DATA_W-LVL_W){1'b0}}, level};
    else if (sel.hstate) value = hstate;
    else if (sel.tbase)  value = tbase;
    else if (sel.ident)  value = IDENT;
    else if (sel.queue)  value = qptr[sel.qidx];
  end
endmodule

// File: rtl/priv_ctl_regs.sv
module priv_ctl_regs #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 5,
  parameter int LVL_W   = 4,
  parameter int IE_BIT  = 1,
  parameter int HID_BIT = 11,
  parameter int TBA_LOW = 15,
  parameter int NWIN    = 8,
  parameter int MAXTL   = 6,
  parameter int MAXGL   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              recheck,
  output logic              err
);
  import prf_pkg::*;

  localparam logic [DATA_W-1:0] TBA_MASK = {DATA_W{1'b1}} << TBA_LOW;
  localparam logic [DATA_W-1:0] HID_SET  = DATA_W'(1) << HID_BIT;
  localparam logic [DATA_W-1:0] IDENT    =
    {{(DATA_W-24){1'b0}}, 8'(MAXGL), 8'(MAXTL), 8'(NWIN)};

  sel_t                       sel;
  logic [DATA_W-1:0]          pstate_q, hstate_q, tbase_q, rd_val;
  logic [LVL_W-1:0]           level_q;
  logic [QN-1:0][DATA_W-1:0]  qptr_q;
  logic                       fire, bad;

  prf_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

  prf_recheck #(.LVL_W(LVL_W)) u_rchk (
    .sel(sel), .wr_en(wr_en),
    .ie_now(pstate_q[IE_BIT]), .ie_new(wdata[IE_BIT]),
    .lvl_now(level_q), .lvl_new(wdata[LVL_W-1:0]),
    .fire(fire)
  );

  prf_readmux #(.DATA_W(DATA_W), .LVL_W(LVL_W), .QN(QN), .IDENT(IDENT)) u_rmux (
    .sel(sel), .pstate(pstate_q), .level(level_q), .hstate(hstate_q),
    .tbase(tbase_q), .qptr(qptr_q), .value(rd_val)
  );

  always_comb begin
    bad = (wr_en & (~sel.known | sel.ident)) | (rd_en & ~sel.known);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pstate_q <= '0;
      level_q  <= '0;
      hstate_q <= HID_SET;
      tbase_q  <= '0;
      qptr_q   <= '0;
    end else if (wr_en) begin
      if (sel.pstate) pstate_q <= wdata;
      if (sel.level)  level_q  <= wdata[LVL_W-1:0];
      if (sel.hstate) hstate_q <= wdata | HID_SET;
      if (sel.tbase)  tbase_q  <= wdata & TBA_MASK;
      for (int i = 0; i < QN; i++)
        if (sel.queue && (sel.qidx == QIDX_W'(i))) qptr_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      recheck <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val & (sel.tbase ? TBA_MASK : {DATA_W{1'b1}});
      recheck <= fire;
      err     <= bad;
    end
  end
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 5,
  parameter int LVL_W   = 4,
  parameter int HID_BIT = 11,
  parameter int TBA_LOW = 15,
  parameter int NWIN    = 8,
  parameter int MAXTL   = 6,
  parameter int MAXGL   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              recheck,
  input logic              err,
  input logic [LVL_W-1:0]  level_q
);
  localparam logic [DATA_W-1:0] IDV =
    {{(DATA_W-24){1'b0}}, 8'(MAXGL), 8'(MAXTL), 8'(NWIN)};

  p_recheck_cause_r10: assert property (@(posedge clk) disable iff (rst)
    recheck |-> $past(wr_en));
  p_err_cause_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(wr_en || rd_en));
  p_queue_recheck_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr >> 3) == ADDR_W'(1)) |=> recheck);
  p_level_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(1) && wdata[LVL_W-1:0] >= level_q) |=> !recheck);
  p_ident_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(4)) |=> (err && !recheck));
  p_tbase_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(3)) |=> (rdata[TBA_LOW-1:0] == '0));
  p_ident_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(4)) |=> (rdata == IDV));
  p_hid_read_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(2)) |=> rdata[HID_BIT]);
endmodule

bind priv_ctl_regs prf_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W), .HID_BIT(HID_BIT),
  .TBA_LOW(TBA_LOW), .NWIN(NWIN), .MAXTL(MAXTL), .MAXGL(MAXGL)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .recheck(recheck), .err(err),
  .level_q(level_q)
);

// File: tb/sim_priv_ctl_regs.sv
`timescale 1ns/1ps
module sim_priv_ctl_regs;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          recheck, err;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] s_rd;
  logic          s_rc, s_er;

  priv_ctl_regs #(.DATA_W(DW), .ADDR_W(AW), .LVL_W(4), .IE_BIT(1),
    .HID_BIT(11), .TBA_LOW(15), .NWIN(8), .MAXTL(6), .MAXGL(2)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .recheck(recheck), .err(err));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic r, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = AW'(a); wdata = d;
    @(posedge clk); #1;
    s_rd = rdata; s_rc = recheck; s_er = err;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic idle_check(input string tag);
    @(posedge clk); #1;
    check({tag, " recheck low"}, DW'(recheck), 0);
    check({tag, " err low"}, DW'(err), 0);
  endtask

  task automatic t_reset;
    check("R1 recheck after reset", DW'(recheck), 0);
    check("R1 err after reset", DW'(err), 0);
    access(0, 1, 0, 0); check("R1 pstate", s_rd, 0);
    access(0, 1, 1, 0); check("R1 level", s_rd, 0);
    access(0, 1, 2, 0); check("R1 hstate", s_rd, 32'h800);
    access(0, 1, 3, 0); check("R1 tbase", s_rd, 0);
    for (int i = 0; i < 8; i++) begin
      access(0, 1, 8 + i, 0); check("R1 queue", s_rd, 0);
    end
  endtask

  task automatic t_pstate;
    access(1, 0, 0, 32'h0); check("R2 ie stays 0", DW'(s_rc), 0);
    access(1, 0, 0, 32'h2); check("R2 ie rise", DW'(s_rc), 1);
    idle_check("R10 pulse width");
    access(1, 0, 0, 32'h3); check("R2 ie stays 1", DW'(s_rc), 0);
    access(1, 0, 0, 32'h0); check("R2 ie fall", DW'(s_rc), 0);
    access(1, 0, 0, 32'hA); check("R2 ie rise again", DW'(s_rc), 1);
    access(0, 1, 0, 0); check("R2 readback", s_rd, 32'hA);
  endtask

  task automatic t_level;
    access(1, 0, 1, 5);  check("R3 raise", DW'(s_rc), 0);
    access(1, 0, 1, 7);  check("R3 raise more", DW'(s_rc), 0);
    access(1, 0, 1, 7);  check("R3 equal", DW'(s_rc), 0);
    access(1, 0, 1, 3);  check("R3 lower", DW'(s_rc), 1);
    access(1, 0, 1, 32'h1F); check("R3 wide value no recheck", DW'(s_rc), 0);
    access(0, 1, 1, 0);  check("R3 truncated", s_rd, 32'hF);
  endtask

  task automatic t_queue;
    for (int i = 0; i < 8; i++) begin
      access(1, 0, 8 + i, 32'h1000 + 32'(i) * 32'h111);
      check("R4 queue recheck", DW'(s_rc), 1);
    end
    for (int i = 0; i < 8; i++) begin
      access(0, 1, 8 + i, 0);
      check("R4 queue readback", s_rd, 32'h1000 + 32'(i) * 32'h111);
    end
  endtask

  task automatic t_tbase;
    access(1, 0, 3, 32'hFFFF_FFFF); check("R5 no recheck", DW'(s_rc), 0);
    access(0, 1, 3, 0); check("R5 all ones masked", s_rd, 32'hFFFF_8000);
    access(1, 0, 3, 32'h1234_5678);
    access(0, 1, 3, 0); check("R5 pattern masked", s_rd, 32'h1234_0000);
    idle_check("R10 rdata holds");
    check("R10 rdata value held", rdata, 32'h1234_0000);
  endtask

  task automatic t_hstate;
    access(1, 0, 2, 32'h0);   access(0, 1, 2, 0); check("R6 zero write", s_rd, 32'h800);
    access(1, 0, 2, 32'h5);   access(0, 1, 2, 0); check("R6 bits kept", s_rd, 32'h805);
  endtask

  task automatic t_ident;
    access(0, 1, 4, 0); check("R7 value", s_rd, 32'h0002_0608);
    check("R7 no err", DW'(s_er), 0);
    access(1, 0, 4, 32'hFFFF_FFFF); check("R8 err", DW'(s_er), 1);
    check("R8 no recheck", DW'(s_rc), 0);
    idle_check("R10 err width");
    access(0, 1, 4, 0); check("R8 unchanged", s_rd, 32'h0002_0608);
  endtask

  task automatic t_unmapped;
    access(0, 1, 5, 0); check("R9 read zero", s_rd, 0);
    check("R9 read err", DW'(s_er), 1);
    idle_check("R9 err width");
    access(0, 1, 20, 0); check("R9 high read err", DW'(s_er), 1);
    access(1, 0, 20, 32'hDEAD_BEEF); check("R9 write err", DW'(s_er), 1);
    check("R9 write no recheck", DW'(s_rc), 0);
    access(1, 0, 6, 32'hDEAD_BEEF); check("R9 write err low map", DW'(s_er), 1);
    access(0, 1, 3, 0); check("R9 tbase untouched", s_rd, 32'h1234_0000);
    access(0, 1, 0, 0); check("R9 pstate untouched", s_rd, 32'hA);
  endtask

  task automatic t_same_cycle;
    access(1, 1, 1, 2); check("R10 read sees old level", s_rd, 32'hF);
    check("R10 lower level recheck", DW'(s_rc), 1);
    access(0, 1, 1, 0); check("R10 new level", s_rd, 32'h2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_pstate();
    t_level();
    t_queue();
    t_tbase();
    t_hstate();
    t_ident();
    t_unmapped();
    t_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule